// File: doc/BRIEF.md
# Serial Flash Page Program Buffer

This block sits behind the serial front end of a flash device and handles the data half of a page-program command. When the front end reports that a program command has begun, the block takes the 24-bit start address, the write-enable state and the result of the protection lookup for the target page. It then gathers the incoming data bits into bytes, one bit per strobe in single mode or two bits per strobe in dual mode, and places each byte in a 256-entry staging buffer. A fill pointer starts at the low address byte and wraps inside the page. A per-entry valid flag records which offsets received data.

When chip select rises, the block either discards the command or starts a self-timed program cycle. The cycle lasts a parameterised number of clocks. During the first 256 clocks of that cycle the staged bytes are merged into the array with an AND, so bits can only go from 1 to 0. Busy stays high for the whole cycle. When it ends, a one-cycle pulse tells the status logic to clear its write-enable latch. The array is a small on-block store of `MEM_PAGES` pages, selected by the low page bits of the address, and it has a combinational read port.

Top module: `page_prog_buf`

## Requirements
- R1: During and after a synchronous reset, busy and wel_clr are 0, the array reads 0xFF at every address, and no command is in progress.
- R2: The first byte lands at the offset given by start_addr[7:0]. Each later byte goes to the next offset, wrapping from 0xFF to 0x00 inside the page chosen by start_addr[8 +: log2(MEM_PAGES)]. The array address is {page, offset}.
- R3: If more than 256 bytes arrive, each offset holds the last byte written to it, so the most recent 256 bytes are programmed.
- R4: A command that starts while wel_in is 0 is ignored: no busy and no change to the array.
- R5: A command that starts while prot_in is 1 is ignored: no busy and no change to the array.
- R6: Bytes are sent most significant bit first. In single mode (dual_in=0 at command start) each bit_vld strobe carries bit_data[0]. In dual mode each strobe carries two bits, with bit_data[1] the more significant of the pair.
- R7: If cs_rise is sampled at a clock edge while a command is collecting, the byte boundary is clean and at least one byte has arrived, then busy is 1 from that edge on for exactly PROG_CYCLES cycles.
- R8: A programmed offset ends up holding old_value AND new_value.
- R9: Offsets in the page that received no byte keep their previous value.
- R10: If cs_rise arrives when part of a byte has been received, or when no byte has arrived at all, the whole command is discarded: no busy and no change to the array.
- R11: wel_clr is high for exactly one cycle, the first cycle after busy falls.
- R12: While busy is high, cmd_start, bit_vld and cs_rise have no effect: the busy length and the array contents are unchanged by them.
- R13: A bit_vld strobe that completes a byte in the same cycle as cs_rise is counted before the boundary check, so that byte is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle pulse marking the start of a program command |
| start_addr | input | 24 | Start address, sampled with cmd_start |
| dual_in | input | 1 | Selects two bits per strobe, sampled with cmd_start |
| wel_in | input | 1 | Write-enable latch state, sampled with cmd_start |
| prot_in | input | 1 | Target page is protected, sampled with cmd_start |
| bit_vld | input | 1 | Data strobe |
| bit_data | input | 2 | Data bits; only bit 0 is used in single mode |
| cs_rise | input | 1 | One-cycle pulse marking the chip-select rising edge |
| rd_addr | input | log2(MEM_PAGES)+8 | Array read address |
| busy | output | 1 | Self-timed program cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
Two things can happen in the same cycle: the strobe that completes the final byte and the chip-select rising edge. This also means the boundary check and the "any byte received" check see a buffer that is still being written. The bench drives both signals on one falling edge, once with a clean final byte and once with a trailing partial byte. It then checks that the first case programs the final byte and the second leaves busy low and the array untouched. A second overlap, a new command arriving while the program cycle runs, is judged by the busy length and a full array comparison against the bench's own model.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} pp_state_e;

    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
    } pp_shift_s;

    // Advance the byte assembler by one strobe, MSB first.
    function automatic pp_shift_s shift_step(pp_shift_s cur, logic dual, logic [1:0] din);
        pp_shift_s nx;
        if (dual) begin
            nx.sh  = {cur.sh[5:0], din};
            nx.cnt = cur.cnt + 3'd2;
        end else begin
            nx.sh  = {cur.sh[6:0], din[0]};
            nx.cnt = cur.cnt + 3'd1;
        end
        return nx;
    endfunction
endpackage

// File: rtl/pp_deser.sv
module pp_deser
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic       dual,
    input  logic [1:0] din,
    output logic       done,
    output logic [7:0] byte_o,
    output logic       mid
);
    pp_shift_s cur_q, nxt;

    always_comb begin
        nxt    = shift_step(cur_q, dual, din);
        done   = en && (nxt.cnt == 3'd0);
        byte_o = nxt.sh;
        // the boundary state after this cycle's strobe, if any
        mid    = en ? (nxt.cnt != 3'd0) : (cur_q.cnt != 3'd0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_q <= '0;
        end else if (en) begin
            cur_q <= nxt;
        end
    end
endmodule

// File: rtl/pp_pagebuf.sv
module pp_pagebuf
    import pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [OFF_W-1:0] start_off,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic [OFF_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_vld,
    output logic             any_vld
);
    logic [7:0]            stage [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [OFF_W-1:0]      off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            off_q <= '0;
        end else if (clr) begin
            vld_q <= '0;
            off_q <= start_off;
        end else if (wr) begin
            vld_q[off_q] <= 1'b1;
            off_q        <= off_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !clr) begin
            stage[off_q] <= wdata;
        end
    end

    assign rd_data = stage[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;
endmodule

// File: rtl/pp_seq.sv
module pp_seq
    import pp_pkg::*;
#(
    parameter int PROG_CYCLES = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             wel_in,
    input  logic             prot_in,
    input  logic             cs_rise,
    input  logic             mid_byte,
    input  logic             have_data,
    output logic             accept,
    output logic             load,
    output logic             busy,
    output logic             wel_clr,
    output logic             prog_we,
    output logic [OFF_W-1:0] prog_idx
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    pp_state_e     state_q;
    logic [CW-1:0] cnt_q;

    assign accept   = (state_q == ST_IDLE) && cmd_start && wel_in && !prot_in;
    assign load     = (state_q == ST_LOAD);
    assign busy     = (state_q == ST_PROG);
    assign prog_we  = busy && (cnt_q < CW'(PAGE_BYTES));
    assign prog_idx = cnt_q[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wel_clr <= 1'b0;
        end else begin
            wel_clr <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_LOAD;
                ST_LOAD: if (cs_rise) begin
                    if (!mid_byte && have_data) begin
                        state_q <= ST_PROG;
                        cnt_q   <= '0;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_PROG: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(PROG_CYCLES - 1)) begin
                        state_q <= ST_IDLE;
                        wel_clr <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/page_prog_buf.sv
module page_prog_buf
    import pp_pkg::*;
#(
    parameter int MEM_PAGES   = 4,
    parameter int PROG_CYCLES = 300,
    localparam int PG_W       = $clog2(MEM_PAGES),
    localparam int MA_W       = PG_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_start,
    input  logic [23:0]     start_addr,
    input  logic            dual_in,
    input  logic            wel_in,
    input  logic            prot_in,
    input  logic            bit_vld,
    input  logic [1:0]      bit_data,
    input  logic            cs_rise,
    input  logic [MA_W-1:0] rd_addr,
    output logic            busy,
    output logic            wel_clr,
    output logic [7:0]      rd_data
);
    localparam int MEM_DEPTH = MEM_PAGES * PAGE_BYTES;

    logic             accept, load, prog_we;
    logic [OFF_W-1:0] prog_idx;
    logic             dual_q;
    logic [PG_W-1:0]  pg_q;
    logic             b_done, b_mid;
    logic [7:0]       b_data;
    logic [7:0]       st_data;
    logic             st_vld, st_any;
    logic             mem_wr;
    logic [7:0]       arr [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            dual_q <= 1'b0;
            pg_q   <= '0;
        end else if (accept) begin
            dual_q <= dual_in;
            pg_q   <= start_addr[OFF_W +: PG_W];
        end
    end

    pp_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .en     (bit_vld && load),
        .dual   (dual_q),
        .din    (bit_data),
        .done   (b_done),
        .byte_o (b_data),
        .mid    (b_mid)
    );

    pp_pagebuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .start_off (start_addr[OFF_W-1:0]),
        .wr        (b_done),
        .wdata     (b_data),
        .rd_idx    (prog_idx),
        .rd_data   (st_data),
        .rd_vld    (st_vld),
        .any_vld   (st_any)
    );

    pp_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .wel_in    (wel_in),
        .prot_in   (prot_in),
        .cs_rise   (cs_rise),
        .mid_byte  (b_mid),
        .have_data (st_any || b_done),
        .accept    (accept),
        .load      (load),
        .busy      (busy),
        .wel_clr   (wel_clr),
        .prog_we   (prog_we),
        .prog_idx  (prog_idx)
    );

    assign mem_wr = prog_we && st_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) arr[i] <= 8'hFF;
        end else if (mem_wr) begin
            arr[{pg_q, prog_idx}] <= arr[{pg_q, prog_idx}] & st_data;
        end
    end

    assign rd_data = arr[rd_addr];
endmodule

// File: rtl/pp_prog_chk.sv
module pp_prog_chk #(
    parameter int PROG_CYCLES = 300
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic wel_clr,
    input logic cs_rise,
    input logic load,
    input logic mem_wr
);
    localparam int CW = $clog2(PROG_CYCLES + 1) + 1;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= '0;
        else              run_q <= run_q + 1'b1;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !wel_clr));
    // R7
    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == CW'(PROG_CYCLES)));
    // R7, R10
    a_r7_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cs_rise) && $past(load)));
    // R11
    a_r11_clr_after_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wel_clr);
    // R11
    a_r11_clr_single: assert property (@(posedge clk) disable iff (rst)
        wel_clr |=> !wel_clr);
    // R12
    a_r12_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> busy);
endmodule

bind page_prog_buf pp_prog_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .wel_clr (wel_clr),
    .cs_rise (cs_rise),
    .load    (load),
    .mem_wr  (mem_wr)
);

// File: tb/page_prog_buf_bench.sv
module page_prog_buf_bench;
    localparam int CLK_P = 10;
    localparam int PAGES = 4;
    localparam int PROG  = 270;
    localparam int MA_W  = 10;
    localparam int DEPTH = PAGES * 256;

    typedef struct packed {
        logic [23:0] addr;
        logic        dual;
        logic [9:0]  n;
        logic [7:0]  base;
        logic [7:0]  step;
        logic [9:0]  probe;
        logic [7:0]  expv;
    } vec_t;

    // probe values worked out by hand from the requirements
    localparam vec_t TBL [4] = '{
        '{24'h000010, 1'b0, 10'd4,   8'hA5, 8'h01, 10'h012, 8'hA7},  // R2 R6 single
        '{24'h0001FE, 1'b1, 10'd4,   8'h3C, 8'h11, 10'h100, 8'h5E},  // R2 wrap, R6 dual
        '{24'h000012, 1'b0, 10'd1,   8'h0F, 8'h00, 10'h012, 8'h07},  // R8 AND
        '{24'h000280, 1'b1, 10'd300, 8'h00, 8'h01, 10'h280, 8'h40}   // R3 overflow
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_start = 1'b0;
    logic [23:0]     start_addr = '0;
    logic            dual_in = 1'b0;
    logic            wel_in = 1'b0;
    logic            prot_in = 1'b0;
    logic            bit_vld = 1'b0;
    logic [1:0]      bit_data = '0;
    logic            cs_rise = 1'b0;
    logic [MA_W-1:0] rd_addr = '0;
    logic            busy, wel_clr;
    logic [7:0]      rd_data;

    int total = 0;
    int bad = 0;
    logic done_flag = 1'b0;
    logic [7:0] model [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    page_prog_buf #(.MEM_PAGES(PAGES), .PROG_CYCLES(PROG)) u_page_prog_buf (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .start_addr(start_addr),
        .dual_in(dual_in), .wel_in(wel_in), .prot_in(prot_in), .bit_vld(bit_vld),
        .bit_data(bit_data), .cs_rise(cs_rise), .rd_addr(rd_addr),
        .busy(busy), .wel_clr(wel_clr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int k, input logic [7:0] base, input logic [7:0] step);
        logic [9:0] kk = 10'(k);
        return 8'(base + step * kk[7:0] + {kk[9:8], 6'b0});
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic dual, input logic with_cs);
        if (dual) begin
            for (int i = 3; i >= 0; i--) begin
                @(negedge clk);
                bit_vld = 1'b1; bit_data = b[2*i +: 2]; cs_rise = with_cs && (i == 0);
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk);
                bit_vld = 1'b1; bit_data = {1'b0, b[i]}; cs_rise = with_cs && (i == 0);
            end
        end
    endtask

    // issues a command and updates the model when it should program
    task automatic run_cmd(input logic [23:0] addr, input logic dual, input int n,
                           input logic [7:0] base, input logic [7:0] step,
                           input logic wel, input logic prot, input int extra,
                           input logic coincide, input logic upd);
        logic [7:0] stg [256];
        logic       sv  [256];
        logic [7:0] off;
        for (int i = 0; i < 256; i++) sv[i] = 1'b0;
        @(negedge clk);
        cmd_start = 1'b1; start_addr = addr; dual_in = dual; wel_in = wel; prot_in = prot;
        @(negedge clk);
        cmd_start = 1'b0;
        off = addr[7:0];
        for (int k = 0; k < n; k++) begin
            send_byte(byte_of(k, base, step), dual, coincide && (k == n - 1) && (extra == 0));
            stg[off] = byte_of(k, base, step); sv[off] = 1'b1; off = off + 8'd1;
        end
        for (int j = 0; j < extra; j++) begin
            @(negedge clk);
            bit_vld = 1'b1; bit_data = 2'b01; cs_rise = coincide && (j == extra - 1);
        end
        @(negedge clk);
        bit_vld = 1'b0;
        if (!coincide) begin
            cs_rise = 1'b1;
            @(negedge clk);
        end
        cs_rise = 1'b0;
        if (upd && wel && !prot && extra == 0 && n > 0) begin
            for (int i = 0; i < 256; i++)
                if (sv[i]) model[{addr[9:8], 8'(i)}] &= stg[i];
        end
    endtask

    task automatic wait_prog(input string req);
        int cnt = 0;
        while (busy && cnt < PROG + 10) begin
            cnt++;
            @(negedge clk);
        end
        check({req, " busy length"}, cnt, PROG);
        check({req, " R11 wel_clr pulse"}, wel_clr, 1);
        @(negedge clk);
        check({req, " R11 wel_clr single"}, wel_clr, 0);
    endtask

    task automatic compare_all(input string req);
        int miss = 0;
        logic [7:0] fa = '0, fe = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = MA_W'(a);
            #1;
            if (rd_data !== model[a]) begin
                if (miss == 0) begin fa = rd_data; fe = model[a]; end
                miss++;
            end
        end
        check({req, " array vs model"}, {fa, 24'(miss)}, {fe, 24'd0});
    endtask

    task automatic probe(input string req, input logic [9:0] a, input logic [7:0] e);
        rd_addr = a;
        #1;
        check(req, rd_data, e);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 busy during reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 wel_clr after reset", wel_clr, 0);
        compare_all("R1");

        // table walk: R2 R3 R6 R7 R8 R9 R11
        foreach (TBL[i]) begin
            run_cmd(TBL[i].addr, TBL[i].dual, int'(TBL[i].n), TBL[i].base, TBL[i].step,
                    1'b1, 1'b0, 0, 1'b0, 1'b1);
            check("R7 busy after cs_rise", busy, 1);
            wait_prog("R7");
            probe("R2 R3 R8 probe", TBL[i].probe, TBL[i].expv);
            compare_all("R9 table");
        end

        // R4 write enable low
        run_cmd(24'h000020, 1'b0, 2, 8'h00, 8'h00, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        check("R4 no busy", busy, 0);
        compare_all("R4");
        // R5 protected page
        run_cmd(24'h000020, 1'b0, 2, 8'h00, 8'h00, 1'b1, 1'b1, 0, 1'b0, 1'b1);
        check("R5 no busy", busy, 0);
        compare_all("R5");
        // R10 partial byte, single and dual, and no data
        run_cmd(24'h000030, 1'b0, 2, 8'h00, 8'h00, 1'b1, 1'b0, 3, 1'b0, 1'b1);
        check("R10 partial single no busy", busy, 0);
        run_cmd(24'h000030, 1'b1, 1, 8'h00, 8'h00, 1'b1, 1'b0, 1, 1'b0, 1'b1);
        check("R10 partial dual no busy", busy, 0);
        run_cmd(24'h000030, 1'b0, 0, 8'h00, 8'h00, 1'b1, 1'b0, 0, 1'b0, 1'b1);
        check("R10 empty no busy", busy, 0);
        compare_all("R10");

        // R13 strobe and cs_rise together, clean then partial
        run_cmd(24'h000300, 1'b0, 1, 8'h81, 8'h00, 1'b1, 1'b0, 0, 1'b1, 1'b1);
        check("R13 busy on coincident edge", busy, 1);
        wait_prog("R13");
        probe("R13 last byte programmed", 10'h300, 8'h81);
        run_cmd(24'h000310, 1'b1, 2, 8'h00, 8'h00, 1'b1, 1'b0, 1, 1'b1, 1'b1);
        check("R13 R10 coincident partial no busy", busy, 0);
        compare_all("R13");

        // R12 command during busy
        run_cmd(24'h000140, 1'b0, 3, 8'hF0, 8'h01, 1'b1, 1'b0, 0, 1'b0, 1'b1);
        check("R12 busy started", busy, 1);
        run_cmd(24'h000150, 1'b0, 2, 8'h00, 8'h00, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        begin
            int cnt = 0;
            while (busy && cnt < PROG + 10) begin cnt++; @(negedge clk); end
            check("R12 busy length unchanged", cnt + 20, PROG);
        end
        compare_all("R12");

        done_flag = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule